// File: doc/BRIEF.md
# DMA Request Source Selector

This block sits between a chip's peripheral request lines and the request inputs of one or more DMA controllers. Software writes a 10-bit source number for every channel of every controller into a bank of select registers. Each channel's request output then follows the peripheral line that number names. The all-ones code means the channel has no source and keeps its request low.

Three channel selectors share each 32-bit register. The register bank is reached through a plain word-addressed read/write port. Each controller owns a fixed window of six words, and the word inside the window is picked by the channel group. Reads are combinational. Request outputs are registered, so a channel's request is the selected line delayed by one clock.

Top module: `dma_src_sel`

## Requirements
- R1: After reset every select field holds 0x3FF and every request output is 0.
- R2: The register for controller n and group i sits at word address 0x1F4 + 6·n + i, which is byte offset 0x7D0 + 0x18·n + 4·i. A group is mapped only if it holds at least one existing channel.
- R3: Channel c of a controller lives in group c/3, in field c mod 3. Field k occupies data bits [10k+9:10k], so the fields are at [9:0], [19:10] and [29:20].
- R4: A write to a mapped register loads each existing channel field of that register from the write data. It leaves every field of every other register unchanged, and the written values read back.
- R5: Bits [31:30] of every register read as 0. A field position with no channel behind it reads 0 and ignores writes.
- R6: A read of an unmapped word returns 0. A write to an unmapped word changes no field.
- R7: Request output bit n·NUM_CHAN + c equals, one clock later, the source line whose number is held in that channel's field.
- R8: A field holding 0x3FF, or any number not below NUM_SRC, drives its request output to 0.
- R9: A write that changes a field takes effect on the request sampled at the clock edge after the writing edge. The edge that performs the write still samples with the old selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_req | input | NUM_SRC | Peripheral request lines |
| req_out | output | NUM_CTRL·NUM_CHAN | Per-channel DMA request, registered |

## Verification
A selector write and the sampling of the request lines can fall on the same clock edge. The bench provokes this on almost every cycle by changing the source lines together with random writes to mapped registers. It predicts each request from the selection held before the write. One directed case moves a channel onto a line that is already high in the writing cycle. The output is judged low on that edge and high on the next.

// File: rtl/dma_src_sel.sv
module dma_src_sel #(
  parameter int NUM_CTRL = 2,
  parameter int NUM_CHAN = 8,
  parameter int NUM_SRC  = 256,
  parameter int ADDR_W   = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [NUM_SRC-1:0]           src_req,
  output logic [NUM_CTRL*NUM_CHAN-1:0] req_out
);
  localparam int SEL_W     = 10;
  localparam int NCH       = NUM_CTRL * NUM_CHAN;
  localparam int STRIDE    = 6;
  localparam int BASE_WORD = 'h1F4;
  localparam int SRC_IW    = $clog2(NUM_SRC);
  localparam logic [SEL_W-1:0] NONE = '1;

  logic [NCH-1:0][SEL_W-1:0] sel_q;
  logic [(1<<SRC_IW)-1:0]    src_pad;
  logic [ADDR_W-1:0]         off, ctrl_sel, grp_sel;
  logic                      in_map;
  logic [31:0]               rd_part [NCH];
  wire                       unused_hi = ^bus_wdata[31:30];

  assign src_pad  = (1<<SRC_IW)'(src_req);
  assign off      = bus_addr - ADDR_W'(BASE_WORD);
  assign in_map   = (bus_addr >= ADDR_W'(BASE_WORD)) && (off < ADDR_W'(NUM_CTRL*STRIDE));
  assign ctrl_sel = off / ADDR_W'(STRIDE);
  assign grp_sel  = off % ADDR_W'(STRIDE);

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    localparam int N = j / NUM_CHAN;
    localparam int C = j % NUM_CHAN;
    localparam int G = C / 3;
    localparam int K = C % 3;
    logic hit;
    logic [SEL_W-1:0] s;

    assign s   = sel_q[j];
    assign hit = in_map && ctrl_sel == ADDR_W'(N) && grp_sel == ADDR_W'(G);
    assign rd_part[j] = hit ? (32'(s) << (SEL_W*K)) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[j]   <= NONE;
        req_out[j] <= 1'b0;
      end else begin
        if (bus_wr && hit) sel_q[j] <= bus_wdata[SEL_W*K +: SEL_W];
        req_out[j] <= (s != NONE) && (s < SEL_W'(NUM_SRC)) && src_pad[s[SRC_IW-1:0]];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int j = 0; j < NCH; j++) bus_rdata = bus_rdata | rd_part[j];
  end
endmodule

module dma_src_sel_chk #(
  parameter int NUM_CTRL = 2,
  parameter int NUM_CHAN = 8,
  parameter int NUM_SRC  = 256
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                bus_wr,
  input logic [31:0]                         bus_rdata,
  input logic [NUM_SRC-1:0]                  src_req,
  input logic [NUM_CTRL*NUM_CHAN-1:0]        req_out,
  input logic [NUM_CTRL*NUM_CHAN-1:0][9:0]   sel_q
);
  localparam int NCH    = NUM_CTRL * NUM_CHAN;
  localparam int SRC_IW = $clog2(NUM_SRC);
  logic [(1<<SRC_IW)-1:0] src_pad;
  assign src_pad = (1<<SRC_IW)'(src_req);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> req_out == '0);
  a_r5_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[31:30] == 2'b00);
  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr |=> $stable(sel_q));

  for (genvar j = 0; j < NCH; j++) begin : g_a
    a_r8_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[j] >= 10'(NUM_SRC)) |=> !req_out[j]);
    a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[j] < 10'(NUM_SRC)) |=> req_out[j] == $past(src_pad[sel_q[j][SRC_IW-1:0]]));
  end
endmodule

bind dma_src_sel dma_src_sel_chk #(.NUM_CTRL(NUM_CTRL), .NUM_CHAN(NUM_CHAN), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .src_req(src_req), .req_out(req_out), .sel_q(sel_q)
);

// File: tb/dma_src_sel_test.sv
module dma_src_sel_test;
  localparam int NUM_CTRL = 2;
  localparam int NUM_CHAN = 8;
  localparam int NUM_SRC  = 256;
  localparam int ADDR_W   = 10;
  localparam int NCH      = NUM_CTRL * NUM_CHAN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_SRC-1:0] src_req = '0;
  logic [NCH-1:0] req_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [9:0] msel [NCH];
  logic [NCH-1:0] exp_req;

  always #4 clk = ~clk;

  dma_src_sel #(.NUM_CTRL(NUM_CTRL), .NUM_CHAN(NUM_CHAN), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_req(src_req), .req_out(req_out)
  );

  function automatic int decode(input logic [ADDR_W-1:0] w, output int n, output int g);
    int off;
    n = 0; g = 0;
    if (int'(w) < 'h1F4) return 0;
    off = int'(w) - 'h1F4;
    if (off >= NUM_CTRL*6) return 0;
    n = off / 6; g = off % 6;
    return 1;
  endfunction

  function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] w);
    int n, g;
    logic [31:0] d = '0;
    if (decode(w, n, g) == 0) return '0;
    for (int k = 0; k < 3; k++)
      if (g*3 + k < NUM_CHAN) d[10*k +: 10] = msel[n*NUM_CHAN + g*3 + k];
    return d;
  endfunction

  function automatic void model_write(input logic [ADDR_W-1:0] w, input logic [31:0] d);
    int n, g;
    if (decode(w, n, g) == 0) return;
    for (int k = 0; k < 3; k++)
      if (g*3 + k < NUM_CHAN) msel[n*NUM_CHAN + g*3 + k] = d[10*k +: 10];
  endfunction

  function automatic logic [NCH-1:0] model_req(input logic [NUM_SRC-1:0] s);
    logic [NCH-1:0] r = '0;
    for (int j = 0; j < NCH; j++)
      if (int'(msel[j]) < NUM_SRC) r[j] = s[msel[j]];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rand_sel();
    int r = $urandom % 4;
    if (r == 0) return 10'h3FF;
    if (r == 1) return 10'(NUM_SRC + $urandom % (1023 - NUM_SRC));
    return 10'($urandom % NUM_SRC);
  endfunction

  task automatic step(input logic [ADDR_W-1:0] a, input logic wr, input logic [31:0] d,
                      input logic [NUM_SRC-1:0] s, input string req);
    bus_addr = a; bus_wr = wr; bus_wdata = d; src_req = s;
    #1;
    check({req, " read"}, bus_rdata, model_read(a));
    exp_req = model_req(s);
    if (wr) model_write(a, d);
    @(posedge clk); @(negedge clk);
    check({req, " req"}, 32'(req_out), 32'(exp_req));
  endtask

  initial begin
    #1200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NUM_SRC-1:0] s;
    void'($urandom(32'h5EED1234));
    for (int j = 0; j < NCH; j++) msel[j] = 10'h3FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset req", 32'(req_out), 0);
    bus_addr = 10'h1F4; #1;
    check("R1 reset fields", bus_rdata, 32'h3FFFFFFF);
    @(negedge clk);

    // R2/R3/R5: controller 1 group 2 holds channels 6,7 only; field 2 absent
    step(10'h1F4 + 6 + 2, 1'b1, 32'hFFFF_FFFF, '1, "R5 absent field");
    bus_addr = 10'h1F4 + 6 + 2; #1;
    check("R5 top and absent bits", bus_rdata, 32'h000F_FFFF);
    @(negedge clk);
    // R2: group 3 of controller 0 is unmapped for 8 channels
    step(10'h1F4 + 3, 1'b1, 32'h0000_0001, '0, "R6 unmapped write");
    bus_addr = 10'h1F4 + 3; #1;
    check("R6 unmapped read", bus_rdata, 0);
    @(negedge clk);
    step(10'h1F3, 1'b1, 32'h0, '0, "R6 below base");
    step(10'h1F4 + 12, 1'b1, 32'h0, '0, "R6 above top");
    // R3: controller 0 group 1 field 1 is channel 4
    step(10'h1F5, 1'b1, {2'b00, 10'h3FF, 10'd9, 10'h3FF}, '0, "R3 packing");
    s = '0; s[9] = 1'b1;
    step(10'h000, 1'b0, 0, s, "R3 channel4 follows line9");
    check("R3 channel4 only", 32'(req_out), 32'(1 << 4));
    // R9: write channel 0 to line 5 while line 5 is high
    s = '0; s[5] = 1'b1;
    step(10'h1F4, 1'b1, {2'b00, 10'h3FF, 10'h3FF, 10'd5}, s, "R9 same-cycle write");
    check("R9 old selection on write edge", 32'(req_out[0]), 0);
    step(10'h000, 1'b0, 0, s, "R9 new selection next edge");
    check("R9 new selection", 32'(req_out[0]), 1);
    // R8: out-of-range code on channel 0
    step(10'h1F4, 1'b1, {2'b00, 10'h3FF, 10'h3FF, 10'd300}, '1, "R8 out of range");
    step(10'h000, 1'b0, 0, '1, "R8 out of range idle");
    check("R8 idle", 32'(req_out[0]), 0);

    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      for (int b = 0; b < NUM_SRC; b += 32) s[b +: 32] = $urandom;
      if ($urandom % 4 != 0) a = 10'h1F4 + 10'($urandom % (NUM_CTRL*6 + 1)) - 10'($urandom % 2);
      else a = 10'($urandom);
      d = {2'($urandom), rand_sel(), rand_sel(), rand_sel()};
      step(a, ($urandom % 3) != 0, d, s, "R4 R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule